// File: doc/BRIEF.md
# Load Data Alignment Unit

This unit sits between a 32-bit memory read port and the register file write path. It accepts one load at a time: a byte, halfword or word access at a byte address, with a signed/unsigned control. It sends memory an address with its low two bits cleared and holds a read request until memory signals ready. It then captures the full 32-bit word in a holding register.

From the captured word, a lane shifter with a fixed set of paths moves the requested field to bit 0. Bytes can come from any of the four lanes. Halfwords can come only from the lower or upper half. Words can come only from offset 0. Byte and halfword results are sign- or zero-extended to the full width. Any access that needs a path the shifter lacks is rejected with a misalignment pulse. This includes a halfword at offset 1, even though it sits entirely inside one word. A rejected access performs no memory read and produces no result.

Top module: `ld_align_unit`

## Requirements
- R1: After reset, `ld_ready` is 1, while `mem_req`, `res_valid` and `misalign` are all 0.
- R2: For an accepted legal load, `mem_req` rises one cycle after acceptance. `mem_addr` equals the request address with bits 1:0 forced to 0. `mem_req` and `mem_addr` hold steady until `mem_ready` is sampled high.
- R3: Size code 00 is a byte load. Byte offset n (address bits 1:0) selects bits 8n+7:8n of the captured word, for n = 0..3. With `ld_signed`=0, bits 31:8 of the result are 0.
- R4: With `ld_signed`=1, bits 31:8 of a byte result copy bit 7 of the selected byte, and bits 31:16 of a halfword result copy bit 15 of the selected halfword.
- R5: Size code 01 is a halfword load. Offset 0 returns bits 15:0 and offset 2 returns bits 31:16. With `ld_signed`=0 the result is zero-extended.
- R6: Size code 10 is a word load. At offset 0 it returns the captured word unchanged, regardless of `ld_signed`.
- R7: A halfword at offset 1 or 3, a word at any nonzero offset, or size code 11 is rejected. `misalign` pulses for one cycle, starting the cycle after acceptance. There is no `mem_req` and no `res_valid` for that load.
- R8: `res_valid` is high for exactly one cycle: the cycle right after the edge where `mem_ready` was sampled high.
- R9: Only one load is outstanding. `ld_ready` is 0 from acceptance until `res_valid` has dropped, and a `ld_valid` presented during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | Unit idle; a request is accepted when both are high |
| ld_addr | input | 32 | Byte address of the load |
| ld_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| ld_signed | input | 1 | 1 selects sign extension, 0 selects zero extension |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 32 | Word-aligned read address |
| mem_ready | input | 1 | Memory returns data this cycle |
| mem_rdata | input | 32 | Read data from memory |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | 32 | Aligned and extended load result |
| misalign | output | 1 | Rejected-access pulse |

## Verification
Call the acceptance edge E. A misalignment pulse, or the first `mem_req`, is due in the cycle after E. The result is due in the cycle after the edge that samples `mem_ready`, and it is gone one cycle later. Each bench task drives its inputs at a falling edge and samples at the next falling edge, which is exactly one registered stage later. This lets every check land in the one cycle where the requirement places the output, and also confirms the output is absent in the cycle after. Wait-state runs insert idle cycles before `mem_ready` and check, at each falling edge, that the request and address hold and that no result appears early.

// File: rtl/ld_align_pkg.sv
// Shared types for the load alignment unit.
// Assumes: size codes are fixed by the load pipeline that drives the unit.
package ld_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } ld_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_REQ  = 2'b01,
        ST_DONE = 2'b10
    } ld_state_e;

endpackage

// File: rtl/ld_access_decode.sv
// Decides whether the lane shifter has a path for the requested access.
// Assumes: bytes are legal at any offset, halfwords only at even offsets,
// words only at offsets that are a multiple of four; reserved size is illegal.
module ld_access_decode
    import ld_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  ld_size_e             size_i,
    input  logic [OFF_W-1:0]     off_i,
    output logic                 illegal_o
);

    // Classify the access against the wired lane positions.
    always_comb begin
        case (size_i)
            SZ_BYTE: illegal_o = 1'b0;
            SZ_HALF: illegal_o = off_i[0];
            SZ_WORD: illegal_o = (off_i[1:0] != 2'b00);
            default: illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/ld_lane_shifter.sv
// Restricted lane shifter with extension: byte from any lane, halfword from
// even lanes, word from lanes aligned to four. No other source offsets exist.
// Assumes: the offset has already been checked as legal for the size.
module ld_lane_shifter
    import ld_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]            word_i,
    input  logic [$clog2(DATA_W/8)-1:0]  off_i,
    input  ld_size_e                     size_i,
    input  logic                         sgn_i,
    output logic [DATA_W-1:0]            res_o
);

    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int HLANES = LANES / 2;
    localparam int WLANES = LANES / 4;
    localparam int WIDX_W = (WLANES > 1) ? $clog2(WLANES) : 1;

    logic [7:0]  byte_lane [LANES];
    logic [15:0] half_lane [HLANES];
    logic [31:0] word_lane [WLANES];
    logic [OFF_W-2:0]  hidx;
    logic [WIDX_W-1:0] widx;
    logic [7:0]  bsel;
    logic [15:0] hsel;
    logic [31:0] wsel;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_byte
            assign byte_lane[g] = word_i[g*8 +: 8];
        end
        for (g = 0; g < HLANES; g++) begin : g_half
            assign half_lane[g] = word_i[g*16 +: 16];
        end
        for (g = 0; g < WLANES; g++) begin : g_word
            assign word_lane[g] = word_i[g*32 +: 32];
        end
    endgenerate

    assign hidx = off_i[OFF_W-1:1];
    assign widx = WIDX_W'(off_i >> 2);
    assign bsel = byte_lane[off_i];
    assign hsel = half_lane[hidx];
    assign wsel = word_lane[widx];

    // Fill upper bits with the extension value, then place the field at bit 0.
    always_comb begin
        res_o = '0;
        case (size_i)
            SZ_BYTE: begin
                res_o      = (sgn_i && bsel[7]) ? '1 : '0;
                res_o[7:0] = bsel;
            end
            SZ_HALF: begin
                res_o       = (sgn_i && hsel[15]) ? '1 : '0;
                res_o[15:0] = hsel;
            end
            SZ_WORD: begin
                res_o       = (sgn_i && wsel[31]) ? '1 : '0;
                res_o[31:0] = wsel;
            end
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/ld_align_unit.sv
// Load alignment unit: accepts one load, issues a word-aligned read, holds it
// until memory is ready, captures the word, and presents the shifted and
// extended result for one cycle. Illegal offsets are flagged, never fetched.
// Assumes: memory keeps mem_rdata valid in the cycle mem_ready is high.
module ld_align_unit
    import ld_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              ld_signed,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              misalign
);

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    ld_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    ld_size_e          size_q;
    logic              sgn_q;
    logic [DATA_W-1:0] word_q;
    logic              mis_q;
    logic              accept;
    logic              illegal;

    assign accept = ld_valid && (state_q == ST_IDLE);

    ld_access_decode #(.OFF_W(OFF_W)) dec_i (
        .size_i    (ld_size_e'(ld_size)),
        .off_i     (ld_addr[OFF_W-1:0]),
        .illegal_o (illegal)
    );

    // Sequence the load: idle, hold the read request, present the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            sgn_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept && !illegal) begin
                        state_q <= ST_REQ;
                        addr_q  <= ld_addr;
                        size_q  <= ld_size_e'(ld_size);
                        sgn_q   <= ld_signed;
                    end
                end
                ST_REQ: begin
                    if (mem_ready) begin
                        word_q  <= mem_rdata;
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register the one-cycle rejection pulse for an illegal access.
    always_ff @(posedge clk) begin
        if (!rst_n) mis_q <= 1'b0;
        else        mis_q <= accept && illegal;
    end

    ld_lane_shifter #(.DATA_W(DATA_W)) shf_i (
        .word_i (word_q),
        .off_i  (addr_q[OFF_W-1:0]),
        .size_i (size_q),
        .sgn_i  (sgn_q),
        .res_o  (res_data)
    );

    assign ld_ready  = (state_q == ST_IDLE);
    assign mem_req   = (state_q == ST_REQ);
    assign mem_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign res_valid = (state_q == ST_DONE);
    assign misalign  = mis_q;

endmodule

// File: rtl/ld_align_unit_chk.sv
// Protocol checker for the load alignment unit, attached by bind.
// Assumes: synchronous active-low reset on the same clock.
module ld_align_unit_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic              ld_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              misalign
);

    a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    a_r8_valid_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> res_valid);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_req && !res_valid));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !misalign);

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || res_valid) |-> !ld_ready);

    a_r9_no_new_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_ready) |=> !misalign);

endmodule

bind ld_align_unit ld_align_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_ready  (ld_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .misalign  (misalign)
);

// File: tb/ld_align_unit_tb_top.sv
// Directed bench for the load alignment unit; each task checks its own results.
module ld_align_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic        ld_ready;
    logic [31:0] ld_addr = '0;
    logic [1:0]  ld_size = '0;
    logic        ld_signed = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        res_valid;
    logic [31:0] res_data;
    logic        misalign;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    ld_align_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
        .ld_addr(ld_addr), .ld_size(ld_size), .ld_signed(ld_signed),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .res_valid(res_valid), .res_data(res_data),
        .misalign(misalign)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected result built from the requirement text.
    function automatic logic [31:0] model(input logic [31:0] w, input logic [1:0] off,
                                          input logic [1:0] sz, input bit sg);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*off +: 8];
        h = off[1] ? w[31:16] : w[15:0];
        case (sz)
            2'b00:   return {{24{sg & b[7]}}, b};
            2'b01:   return {{16{sg & h[15]}}, h};
            default: return w;
        endcase
    endfunction

    // One load; poke=1 presents a second request while busy.
    task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input bit sg,
                           input int waits, input logic [31:0] w, input bit poke,
                           input string tag);
        bit mis;
        logic [31:0] exp;
        mis = (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
        @(negedge clk);
        chk(ld_ready == 1'b1, {"R9 ready before ", tag}, 32'(ld_ready), 32'd1);
        ld_valid = 1'b1; ld_addr = a; ld_size = sz; ld_signed = sg;
        @(negedge clk);
        ld_valid = 1'b0;
        if (mis) begin
            chk(misalign == 1'b1, {"R7 flag ", tag}, 32'(misalign), 32'd1);
            chk(mem_req == 1'b0, {"R7 no req ", tag}, 32'(mem_req), 32'd0);
            @(negedge clk);
            chk(!misalign && !res_valid && !mem_req, {"R7 quiet after ", tag},
                {29'd0, misalign, res_valid, mem_req}, 32'd0);
        end else begin
            exp = model(w, a[1:0], sz, sg);
            chk(mem_req == 1'b1, {"R2 req ", tag}, 32'(mem_req), 32'd1);
            chk(mem_addr == {a[31:2], 2'b00}, {"R2 addr ", tag}, mem_addr, {a[31:2], 2'b00});
            chk(ld_ready == 1'b0 && misalign == 1'b0, {"R9 busy ", tag},
                {30'd0, ld_ready, misalign}, 32'd0);
            for (int i = 0; i < waits; i++) begin
                if (poke) begin
                    ld_valid = 1'b1; ld_addr = a ^ 32'h0000_0101; ld_size = 2'b11;
                end
                @(negedge clk);
                chk(mem_req && !res_valid && mem_addr == {a[31:2], 2'b00} && !misalign,
                    {"R2 hold ", tag}, mem_addr, {a[31:2], 2'b00});
            end
            ld_valid = 1'b0;
            mem_ready = 1'b1; mem_rdata = w;
            @(negedge clk);
            mem_ready = 1'b0; mem_rdata = 32'hDEAD_BEEF;
            chk(res_valid == 1'b1, {"R8 valid ", tag}, 32'(res_valid), 32'd1);
            chk(res_data == exp, {"R3-6 data ", tag}, res_data, exp);
            @(negedge clk);
            chk(res_valid == 1'b0 && ld_ready == 1'b1 && !mem_req && !misalign,
                {"R8 drop ", tag}, {28'd0, res_valid, ld_ready, mem_req, misalign},
                32'h4);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ld_ready && !mem_req && !res_valid && !misalign, "R1 reset state",
            {28'd0, ld_ready, mem_req, res_valid, misalign}, 32'h8);
        rst_n = 1'b1;
    endtask

    task automatic t_bytes();
        for (int o = 0; o < 4; o++) begin
            do_load(32'h0000_1200 + 32'(o), 2'b00, 1'b0, 0, 32'h8A7F_C311, 1'b0, "R3 byte unsigned");
            do_load(32'h0000_1300 + 32'(o), 2'b00, 1'b1, 1, 32'h8A7F_C311, 1'b0, "R4 byte signed");
        end
    endtask

    task automatic t_halves();
        do_load(32'h0000_2000, 2'b01, 1'b0, 0, 32'h8A7F_C311, 1'b0, "R5 half off0 unsigned");
        do_load(32'h0000_2002, 2'b01, 1'b0, 2, 32'h8A7F_C311, 1'b0, "R5 half off2 unsigned");
        do_load(32'h0000_2000, 2'b01, 1'b1, 0, 32'h8A7F_C311, 1'b0, "R4 half off0 signed");
        do_load(32'h0000_2002, 2'b01, 1'b1, 0, 32'h8A7F_C311, 1'b0, "R4 half off2 signed");
        do_load(32'h0000_2002, 2'b01, 1'b1, 0, 32'h7FFF_0000, 1'b0, "R4 half positive");
    endtask

    task automatic t_word();
        do_load(32'hFFFF_FFFC, 2'b10, 1'b1, 3, 32'h8123_4567, 1'b0, "R6 word signed");
        do_load(32'h0000_0040, 2'b10, 1'b0, 0, 32'hF00D_CAFE, 1'b0, "R6 word unsigned");
    endtask

    task automatic t_reject();
        do_load(32'h0000_3001, 2'b01, 1'b0, 0, 32'h0, 1'b0, "R7 half off1");
        do_load(32'h0000_3003, 2'b01, 1'b1, 0, 32'h0, 1'b0, "R7 half off3");
        do_load(32'h0000_3002, 2'b10, 1'b0, 0, 32'h0, 1'b0, "R7 word off2");
        do_load(32'h0000_3001, 2'b10, 1'b0, 0, 32'h0, 1'b0, "R7 word off1");
        do_load(32'h0000_3000, 2'b11, 1'b0, 0, 32'h0, 1'b0, "R7 reserved size");
        do_load(32'h0000_3002, 2'b01, 1'b0, 0, 32'h1234_5678, 1'b0, "R7 legal after reject");
    endtask

    task automatic t_busy();
        do_load(32'h0000_4001, 2'b00, 1'b1, 4, 32'h0000_8000, 1'b1, "R9 poke while busy");
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_bytes();
        t_halves();
        t_word();
        t_reject();
        t_busy();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule